// File: doc/BRIEF.md
# Split-Line Region Permission Checker

This block judges every access on two memory ports, an instruction-side port and a data-side port, against per-region permission bits. Each port's address space is cut into four areas by movable boundary addresses ("split lines") instead of fixed base/limit pairs. A single shared main line marks the start of the topmost area on both ports. The data port sees that line shifted by a fixed alias offset, so both ports can address the same physical memory through different windows.

Configuration arrives on a one-cycle register write port. It carries five split lines, one permission field per port and a lock register. The allow result for each port is purely combinational from the request inputs and the configuration registers. After reset every permission bit is set, so the checker lets everything through until software narrows the rules. Lock bits can then freeze the split lines and each port's permission field until the next reset.

Top module: `region_perm_checker`

## Requirements
- R1: After reset all split lines are 0, all permission bits are 1 and all lock bits are 0, so every load, store and fetch on the instruction port and every load and store on the data port is allowed.
- R2: The instruction-port area is chosen by priority. An address at or above the main line (select 0) is area 3; otherwise at or above instruction line 1 (select 2) is area 2; otherwise at or above instruction line 0 (select 1) is area 1; otherwise area 0.
- R3: The request type is encoded 0 = load, 1 = store, 2 = fetch, 3 = reserved. The instruction permission field (select 5) holds three bits per area k at bits 3k (read), 3k+1 (write) and 3k+2 (execute). A load needs read, a store needs write, a fetch needs execute, and a reserved type is always denied.
- R4: The data-port area uses data line 0 (select 3), data line 1 (select 4) and the main line plus the fixed alias offset, with the same priority as R2. The data permission field (select 6) holds bit 2k (read) and bit 2k+1 (write) for area k.
- R5: A fetch or reserved-type request on the data port is always denied.
- R6: A write to any split line (selects 0 to 4) whose low nine data bits are not all zero is rejected, and the line keeps its old value.
- R7: The lock register (select 7) is write-one-to-set: bit 0 locks the lines, bit 1 locks the instruction permissions and bit 2 locks the data permissions. Writing zeros clears nothing; only reset clears a lock.
- R8: While the line lock is set, writes to all five split lines are ignored.
- R9: Each permission lock freezes only its own port's permission field. The other port's field stays writable.
- R10: A request with all byte enables clear is allowed on either port, whatever its type and area.
- R11: A configuration write takes effect at the clock edge that samples it, and the allow outputs reflect it combinationally in the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 3 | Configuration register select (0..7) |
| cfgWdata | input | ADDR_W | Configuration write data |
| iAddr | input | ADDR_W | Instruction-port request address |
| iType | input | 2 | Instruction-port request type |
| iByteEn | input | BE_W | Instruction-port byte enables |
| iAllow | output | 1 | Instruction-port access allowed |
| dAddr | input | ADDR_W | Data-port request address |
| dType | input | 2 | Data-port request type |
| dByteEn | input | BE_W | Data-port byte enables |
| dAllow | output | 1 | Data-port access allowed |

## Verification
The bench builds the block with an 18-bit address, a 9-bit alignment, four byte enables and an alias offset of 0x20000. These values put the data-side lines in the upper half of a small address space. Because the space is small, random split lines and random addresses land close to one another. Many random requests then fall exactly on a line, one below it, or in an area squeezed between two lines that are out of order. Misaligned random line writes are common, so the rejection path runs against a constantly changing configuration.

// File: rtl/rpc_pkg.sv
package rpc_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } accKind_t;

  localparam int AREAS  = 4;
  localparam int AREA_W = $clog2(AREAS);
  localparam int SEL_W  = 3;
  localparam int LOCK_W = 3;

  localparam logic [SEL_W-1:0] SEL_MAIN  = 3'd0;
  localparam logic [SEL_W-1:0] SEL_I0    = 3'd1;
  localparam logic [SEL_W-1:0] SEL_I1    = 3'd2;
  localparam logic [SEL_W-1:0] SEL_D0    = 3'd3;
  localparam logic [SEL_W-1:0] SEL_D1    = 3'd4;
  localparam logic [SEL_W-1:0] SEL_IPERM = 3'd5;
  localparam logic [SEL_W-1:0] SEL_DPERM = 3'd6;
  localparam logic [SEL_W-1:0] SEL_LOCK  = 3'd7;

  localparam int LK_LINES = 0;
  localparam int LK_IPERM = 1;
  localparam int LK_DPERM = 2;

  localparam int I_PERM_W = 3 * AREAS;
  localparam int D_PERM_W = 2 * AREAS;

  typedef struct packed {
    logic wrMain;
    logic wrI0;
    logic wrI1;
    logic wrD0;
    logic wrD1;
    logic wrIPerm;
    logic wrDPerm;
  } cfgStrobe_t;

endpackage

// File: rtl/rpc_ctrl.sv
module rpc_ctrl
  import rpc_pkg::*;
#(
  parameter int ALIGN_BITS = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [SEL_W-1:0] cfgSel,
  input  logic [ALIGN_BITS-1:0] cfgLow,
  output cfgStrobe_t       strobe,
  output logic [LOCK_W-1:0] lockVec
);

  logic lineAligned;
  logic lineOpen;

  assign lineAligned = (cfgLow == '0);
  assign lineOpen    = lineAligned && !lockVec[LK_LINES];

  // Decode one write into at most one update strobe for the datapath
  always_comb begin
    strobe = '0;
    if (cfgWe) begin
      case (cfgSel)
        SEL_MAIN:  strobe.wrMain  = lineOpen;
        SEL_I0:    strobe.wrI0    = lineOpen;
        SEL_I1:    strobe.wrI1    = lineOpen;
        SEL_D0:    strobe.wrD0    = lineOpen;
        SEL_D1:    strobe.wrD1    = lineOpen;
        SEL_IPERM: strobe.wrIPerm = !lockVec[LK_IPERM];
        SEL_DPERM: strobe.wrDPerm = !lockVec[LK_DPERM];
        default:   strobe = '0;
      endcase
    end
  end

  // Locks only ever gain bits; reset is the sole way back
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockVec <= '0;
    end else if (cfgWe && (cfgSel == SEL_LOCK)) begin
      lockVec <= lockVec | cfgLow[LOCK_W-1:0];
    end
  end

endmodule

// File: rtl/rpc_port_check.sv
module rpc_port_check
  import rpc_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int BE_W     = 4,
  parameter bit HAS_EXEC = 1'b1,
  localparam int BPA     = HAS_EXEC ? 3 : 2,
  localparam int PERM_W  = BPA * AREAS
) (
  input  logic [ADDR_W-1:0] addr,
  input  accKind_t          kind,
  input  logic [BE_W-1:0]   byteEn,
  input  logic [ADDR_W-1:0] line0,
  input  logic [ADDR_W-1:0] line1,
  input  logic [ADDR_W-1:0] topLine,
  input  logic [PERM_W-1:0] perm,
  output logic              allow
);

  logic [AREAS-1:0]  rdEn;
  logic [AREAS-1:0]  wrEn;
  logic [AREAS-1:0]  exEn;
  logic [AREA_W-1:0] areaIdx;

  for (genvar g = 0; g < AREAS; g++) begin : g_field
    assign rdEn[g] = perm[g*BPA];
    assign wrEn[g] = perm[g*BPA+1];
    if (HAS_EXEC) begin : g_exec
      assign exEn[g] = perm[g*BPA+2];
    end else begin : g_noexec
      assign exEn[g] = 1'b0;
    end
  end

  // Highest boundary wins, so disordered lines still give one area
  always_comb begin
    if (addr >= topLine)    areaIdx = AREA_W'(3);
    else if (addr >= line1) areaIdx = AREA_W'(2);
    else if (addr >= line0) areaIdx = AREA_W'(1);
    else                    areaIdx = AREA_W'(0);
  end

  always_comb begin
    if (byteEn == '0) begin
      allow = 1'b1;
    end else begin
      case (kind)
        ACC_LOAD:  allow = rdEn[areaIdx];
        ACC_STORE: allow = wrEn[areaIdx];
        ACC_FETCH: allow = exEn[areaIdx];
        default:   allow = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/rpc_datapath.sv
module rpc_datapath
  import rpc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BE_W   = 4,
  parameter logic [ADDR_W-1:0] ALIAS_OFS = 'h0002_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrobe_t        strobe,
  input  logic [ADDR_W-1:0] cfgWdata,
  input  logic [ADDR_W-1:0] iAddr,
  input  logic [1:0]        iType,
  input  logic [BE_W-1:0]   iByteEn,
  input  logic [ADDR_W-1:0] dAddr,
  input  logic [1:0]        dType,
  input  logic [BE_W-1:0]   dByteEn,
  output logic              iAllow,
  output logic              dAllow
);

  logic [ADDR_W-1:0]   mainLine;
  logic [ADDR_W-1:0]   iLine0;
  logic [ADDR_W-1:0]   iLine1;
  logic [ADDR_W-1:0]   dLine0;
  logic [ADDR_W-1:0]   dLine1;
  logic [I_PERM_W-1:0] iPerm;
  logic [D_PERM_W-1:0] dPerm;
  logic [ADDR_W-1:0]   dTopLine;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mainLine <= '0;
      iLine0   <= '0;
      iLine1   <= '0;
      dLine0   <= '0;
      dLine1   <= '0;
      iPerm    <= '1;
      dPerm    <= '1;
    end else begin
      if (strobe.wrMain)  mainLine <= cfgWdata;
      if (strobe.wrI0)    iLine0   <= cfgWdata;
      if (strobe.wrI1)    iLine1   <= cfgWdata;
      if (strobe.wrD0)    dLine0   <= cfgWdata;
      if (strobe.wrD1)    dLine1   <= cfgWdata;
      if (strobe.wrIPerm) iPerm    <= cfgWdata[I_PERM_W-1:0];
      if (strobe.wrDPerm) dPerm    <= cfgWdata[D_PERM_W-1:0];
    end
  end

  // The shared boundary, seen through the data-side alias window
  assign dTopLine = mainLine + ALIAS_OFS;

  rpc_port_check #(
    .ADDR_W  (ADDR_W),
    .BE_W    (BE_W),
    .HAS_EXEC(1'b1)
  ) u_iChk (
    .addr   (iAddr),
    .kind   (accKind_t'(iType)),
    .byteEn (iByteEn),
    .line0  (iLine0),
    .line1  (iLine1),
    .topLine(mainLine),
    .perm   (iPerm),
    .allow  (iAllow)
  );

  rpc_port_check #(
    .ADDR_W  (ADDR_W),
    .BE_W    (BE_W),
    .HAS_EXEC(1'b0)
  ) u_dChk (
    .addr   (dAddr),
    .kind   (accKind_t'(dType)),
    .byteEn (dByteEn),
    .line0  (dLine0),
    .line1  (dLine1),
    .topLine(dTopLine),
    .perm   (dPerm),
    .allow  (dAllow)
  );

endmodule

// File: rtl/region_perm_checker.sv
module region_perm_checker
  import rpc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 9,
  parameter int BE_W       = 4,
  parameter logic [ADDR_W-1:0] ALIAS_OFS = 'h0002_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [2:0]        cfgSel,
  input  logic [ADDR_W-1:0] cfgWdata,
  input  logic [ADDR_W-1:0] iAddr,
  input  logic [1:0]        iType,
  input  logic [BE_W-1:0]   iByteEn,
  output logic              iAllow,
  input  logic [ADDR_W-1:0] dAddr,
  input  logic [1:0]        dType,
  input  logic [BE_W-1:0]   dByteEn,
  output logic              dAllow
);

  cfgStrobe_t        strobe;
  logic [LOCK_W-1:0] lockVec;

  rpc_ctrl #(
    .ALIGN_BITS(ALIGN_BITS)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .cfgWe  (cfgWe),
    .cfgSel (cfgSel),
    .cfgLow (cfgWdata[ALIGN_BITS-1:0]),
    .strobe (strobe),
    .lockVec(lockVec)
  );

  rpc_datapath #(
    .ADDR_W   (ADDR_W),
    .BE_W     (BE_W),
    .ALIAS_OFS(ALIAS_OFS)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .cfgWdata(cfgWdata),
    .iAddr   (iAddr),
    .iType   (iType),
    .iByteEn (iByteEn),
    .dAddr   (dAddr),
    .dType   (dType),
    .dByteEn (dByteEn),
    .iAllow  (iAllow),
    .dAllow  (dAllow)
  );

endmodule

// File: rtl/rpc_sva.sv
module rpc_sva
  import rpc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 9,
  parameter int BE_W       = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgWe,
  input logic [2:0]        cfgSel,
  input logic [ADDR_W-1:0] cfgWdata,
  input logic [1:0]        iType,
  input logic [BE_W-1:0]   iByteEn,
  input logic              iAllow,
  input logic [1:0]        dType,
  input logic [BE_W-1:0]   dByteEn,
  input logic              dAllow,
  input cfgStrobe_t        strobe,
  input logic [LOCK_W-1:0] lockVec
);

  logic [4:0] lineStrobes;
  assign lineStrobes = {strobe.wrMain, strobe.wrI0, strobe.wrI1, strobe.wrD0, strobe.wrD1};

  // R7
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(lockVec) & ~lockVec) == '0);

  // R8
  line_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    lockVec[LK_LINES] |-> (lineStrobes == 5'b0));

  // R9
  iperm_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    lockVec[LK_IPERM] |-> !strobe.wrIPerm);

  // R9
  dperm_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    lockVec[LK_DPERM] |-> !strobe.wrDPerm);

  // R6
  misaligned_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && (cfgSel <= SEL_D1) && (cfgWdata[ALIGN_BITS-1:0] != '0)) |-> (lineStrobes == 5'b0));

  // R5
  data_fetch_deny_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((dByteEn != '0) && (dType[1] == 1'b1)) |-> !dAllow);

  // R3
  rsvd_type_deny_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((iByteEn != '0) && (iType == 2'd3)) |-> !iAllow);

  // R10
  no_bytes_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((iByteEn == '0) |-> iAllow) and ((dByteEn == '0) |-> dAllow));

endmodule

bind region_perm_checker rpc_sva #(
  .ADDR_W    (ADDR_W),
  .ALIGN_BITS(ALIGN_BITS),
  .BE_W      (BE_W)
) u_sva (
  .clk     (clk),
  .rstN    (rstN),
  .cfgWe   (cfgWe),
  .cfgSel  (cfgSel),
  .cfgWdata(cfgWdata),
  .iType   (iType),
  .iByteEn (iByteEn),
  .iAllow  (iAllow),
  .dType   (dType),
  .dByteEn (dByteEn),
  .dAllow  (dAllow),
  .strobe  (strobe),
  .lockVec (lockVec)
);

// File: tb/region_perm_checker_test.sv
`timescale 1ns/1ps
module region_perm_checker_test;

  localparam int AW = 18;
  localparam int AB = 9;
  localparam int BW = 4;
  localparam logic [AW-1:0] OFS = 18'h20000;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgWe = 1'b0;
  logic [2:0]    cfgSel = '0;
  logic [AW-1:0] cfgWdata = '0;
  logic [AW-1:0] iAddr = '0;
  logic [1:0]    iType = '0;
  logic [BW-1:0] iByteEn = '0;
  logic          iAllow;
  logic [AW-1:0] dAddr = '0;
  logic [1:0]    dType = '0;
  logic [BW-1:0] dByteEn = '0;
  logic          dAllow;

  int checks = 0;
  int errors = 0;

  // Bench-side copy of the configuration, maintained from the requirements
  logic [AW-1:0] mMain, mI0, mI1, mD0, mD1;
  logic [11:0]   mIPerm;
  logic [7:0]    mDPerm;
  logic [2:0]    mLock;

  always #4 clk = ~clk;

  region_perm_checker #(
    .ADDR_W(AW), .ALIGN_BITS(AB), .BE_W(BW), .ALIAS_OFS(OFS)
  ) uut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgWdata(cfgWdata),
    .iAddr(iAddr), .iType(iType), .iByteEn(iByteEn), .iAllow(iAllow),
    .dAddr(dAddr), .dType(dType), .dByteEn(dByteEn), .dAllow(dAllow)
  );

  function automatic int areaOf(logic [AW-1:0] a, logic [AW-1:0] l0,
                                logic [AW-1:0] l1, logic [AW-1:0] top);
    if (a >= top) return 3;
    if (a >= l1)  return 2;
    if (a >= l0)  return 1;
    return 0;
  endfunction

  function automatic logic expI(logic [AW-1:0] a, logic [1:0] k, logic [BW-1:0] be);
    int ar;
    if (be == '0) return 1'b1;
    if (k == 2'd3) return 1'b0;
    ar = areaOf(a, mI0, mI1, mMain);
    return mIPerm[3*ar + int'(k)];
  endfunction

  function automatic logic expD(logic [AW-1:0] a, logic [1:0] k, logic [BW-1:0] be);
    int ar;
    if (be == '0) return 1'b1;
    if (k[1]) return 1'b0;
    ar = areaOf(a, mD0, mD1, mMain + OFS);
    return mDPerm[2*ar + int'(k)];
  endfunction

  function automatic void modelReset();
    mMain = '0; mI0 = '0; mI1 = '0; mD0 = '0; mD1 = '0;
    mIPerm = '1; mDPerm = '1; mLock = '0;
  endfunction

  function automatic void modelWrite(logic [2:0] sel, logic [AW-1:0] v);
    logic lineOk;
    lineOk = (v[AB-1:0] == '0) && !mLock[0];
    case (sel)
      3'd0: if (lineOk) mMain = v;
      3'd1: if (lineOk) mI0 = v;
      3'd2: if (lineOk) mI1 = v;
      3'd3: if (lineOk) mD0 = v;
      3'd4: if (lineOk) mD1 = v;
      3'd5: if (!mLock[1]) mIPerm = v[11:0];
      3'd6: if (!mLock[2]) mDPerm = v[7:0];
      default: mLock = mLock | v[2:0];
    endcase
  endfunction

  task automatic doWrite(logic [2:0] sel, logic [AW-1:0] v);
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = sel; cfgWdata = v;
    @(posedge clk);
    modelWrite(sel, v);
    #1;
    cfgWe = 1'b0;
  endtask

  task automatic chkI(logic [AW-1:0] a, logic [1:0] k, logic [BW-1:0] be, string req);
    logic e;
    @(negedge clk);
    iAddr = a; iType = k; iByteEn = be;
    #1;
    e = expI(a, k, be);
    checks++;
    if (iAllow !== e) begin
      errors++;
      $display("FAIL %s: iport addr=%h type=%0d be=%b got %b expected %b", req, a, k, be, iAllow, e);
    end
  endtask

  task automatic chkD(logic [AW-1:0] a, logic [1:0] k, logic [BW-1:0] be, string req);
    logic e;
    @(negedge clk);
    dAddr = a; dType = k; dByteEn = be;
    #1;
    e = expD(a, k, be);
    checks++;
    if (dAllow !== e) begin
      errors++;
      $display("FAIL %s: dport addr=%h type=%0d be=%b got %b expected %b", req, a, k, be, dAllow, e);
    end
  endtask

  // Direct value check for cases where the model could share a mistake
  task automatic chkILit(logic [AW-1:0] a, logic [1:0] k, logic e, string req);
    @(negedge clk);
    iAddr = a; iType = k; iByteEn = 4'hF;
    #1;
    checks++;
    if (iAllow !== e) begin
      errors++;
      $display("FAIL %s: iport addr=%h type=%0d got %b expected %b", req, a, k, iAllow, e);
    end
  endtask

  task automatic chkDLit(logic [AW-1:0] a, logic [1:0] k, logic e, string req);
    @(negedge clk);
    dAddr = a; dType = k; dByteEn = 4'hF;
    #1;
    checks++;
    if (dAllow !== e) begin
      errors++;
      $display("FAIL %s: dport addr=%h type=%0d got %b expected %b", req, a, k, dAllow, e);
    end
  endtask

  task automatic applyReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(posedge clk);
    modelReset();
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic knownSetup();
    doWrite(3'd1, 18'h01000);
    doWrite(3'd2, 18'h02000);
    doWrite(3'd0, 18'h03000);
    doWrite(3'd3, 18'h21000);
    doWrite(3'd4, 18'h22000);
    // areas 0..3: read / write / exec / read+write
    doWrite(3'd5, 18'({3'b011, 3'b100, 3'b010, 3'b001}));
    // areas 0..3: read / write / none / read+write
    doWrite(3'd6, 18'({2'b11, 2'b00, 2'b10, 2'b01}));
  endtask

  function automatic logic [AW-1:0] pickAddr();
    logic [AW-1:0] base;
    int sel;
    sel = int'($urandom_range(0, 6));
    case (sel)
      0: base = mI0;
      1: base = mI1;
      2: base = mMain;
      3: base = mD0;
      4: base = mD1;
      5: base = mMain + OFS;
      default: base = AW'($urandom());
    endcase
    return base + AW'($urandom_range(0, 2)) - AW'(1);
  endfunction

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4217));
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: open after reset
    chkILit(18'h00000, 2'd0, 1'b1, "R1");
    chkILit(18'h12345, 2'd1, 1'b1, "R1");
    chkILit(18'h3FFFF, 2'd2, 1'b1, "R1");
    chkDLit(18'h20000, 2'd0, 1'b1, "R1");
    chkDLit(18'h3FFFC, 2'd1, 1'b1, "R1");

    knownSetup();
    // R2 and R3: boundaries and type-to-bit mapping
    chkILit(18'h00FFF, 2'd0, 1'b1, "R2");
    chkILit(18'h00FFF, 2'd1, 1'b0, "R3");
    chkILit(18'h01000, 2'd1, 1'b1, "R2");
    chkILit(18'h01000, 2'd0, 1'b0, "R3");
    chkILit(18'h01FFF, 2'd1, 1'b1, "R2");
    chkILit(18'h02000, 2'd2, 1'b1, "R2");
    chkILit(18'h02FFF, 2'd1, 1'b0, "R3");
    chkILit(18'h03000, 2'd1, 1'b1, "R2");
    chkILit(18'h03000, 2'd2, 1'b0, "R3");
    chkILit(18'h03000, 2'd3, 1'b0, "R3");
    // R4: data port with aliased main line at 0x23000
    chkDLit(18'h20FFF, 2'd0, 1'b1, "R4");
    chkDLit(18'h21000, 2'd1, 1'b1, "R4");
    chkDLit(18'h21000, 2'd0, 1'b0, "R4");
    chkDLit(18'h22FFF, 2'd0, 1'b0, "R4");
    chkDLit(18'h23000, 2'd1, 1'b1, "R4");
    chkDLit(18'h03000, 2'd0, 1'b1, "R4");
    // R5
    chkDLit(18'h23000, 2'd2, 1'b0, "R5");
    chkDLit(18'h00000, 2'd3, 1'b0, "R5");
    // R10
    chkI(18'h00FFF, 2'd1, 4'h0, "R10");
    chkD(18'h22000, 2'd2, 4'h0, "R10");
    // R6: misaligned main write leaves 0x3000 in area 3
    doWrite(3'd0, 18'h03100);
    chkILit(18'h03000, 2'd1, 1'b1, "R6");
    chkILit(18'h030FF, 2'd2, 1'b0, "R6");
    doWrite(3'd3, 18'h20001);
    chkDLit(18'h20FFF, 2'd0, 1'b1, "R6");
    // R11: aligned write visible right after the edge
    doWrite(3'd0, 18'h03200);
    chkILit(18'h03000, 2'd2, 1'b1, "R11");
    chkILit(18'h03200, 2'd1, 1'b1, "R11");

    // Random configuration and traffic against the model
    for (int n = 0; n < 600; n++) begin
      logic [2:0] s;
      logic [AW-1:0] v;
      s = 3'($urandom_range(0, 6));
      v = AW'($urandom());
      if (s <= 3'd4 && $urandom_range(0, 1) == 0) v[AB-1:0] = '0;
      doWrite(s, v);
      for (int m = 0; m < 3; m++) begin
        logic [BW-1:0] be;
        be = ($urandom_range(0, 9) == 0) ? '0 : BW'($urandom());
        chkI(pickAddr(), 2'($urandom()), be, "R11");
        chkD(pickAddr(), 2'($urandom()), be, "R4");
      end
    end

    // R8: line lock freezes the boundaries
    knownSetup();
    doWrite(3'd7, 18'h00001);
    doWrite(3'd0, 18'h03200);
    chkILit(18'h03000, 2'd1, 1'b1, "R8");
    chkILit(18'h03000, 2'd2, 1'b0, "R8");
    doWrite(3'd4, 18'h21800);
    chkDLit(18'h21C00, 2'd1, 1'b1, "R8");
    // R9: instruction perms frozen, data perms still writable
    doWrite(3'd7, 18'h00002);
    doWrite(3'd5, 18'h00000);
    chkILit(18'h00000, 2'd0, 1'b1, "R9");
    doWrite(3'd6, 18'h000FF);
    chkDLit(18'h22000, 2'd0, 1'b1, "R9");
    // R7: writing zeros clears nothing; bit 2 sets the data lock
    doWrite(3'd7, 18'h00000);
    doWrite(3'd5, 18'h00000);
    chkILit(18'h00000, 2'd0, 1'b1, "R7");
    doWrite(3'd7, 18'h00004);
    doWrite(3'd6, 18'h00000);
    chkDLit(18'h22000, 2'd0, 1'b1, "R7");
    for (int n = 0; n < 40; n++) begin
      doWrite(3'($urandom_range(0, 6)), AW'($urandom()) & 18'h3FE00);
      chkI(pickAddr(), 2'($urandom()), 4'hF, "R8");
      chkD(pickAddr(), 2'($urandom()), 4'hF, "R9");
    end

    // R7: reset clears the locks
    applyReset();
    chkILit(18'h00000, 2'd2, 1'b1, "R1");
    doWrite(3'd5, 18'({3'b011, 3'b100, 3'b010, 3'b001}));
    doWrite(3'd0, 18'h03200);
    chkILit(18'h03000, 2'd1, 1'b0, "R7");
    chkILit(18'h03000, 2'd2, 1'b1, "R7");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule